// File: doc/BRIEF.md
# Clock Source and Power-Mode Controller

This block decides where the processor and peripheral clocks come from and when they are allowed to tick. It produces two clock-enable strobes, one for the CPU and one for the peripherals. Both strobes have the same rate and come from one programmable divider. The divider ratio comes from the oscillator-divider field while the bypass source is selected. It comes from the CPU-divider field while the PLL-derived source is selected. Analog PLL behaviour is represented by a lock input only. The actual clock multiplexing lives elsewhere and is driven by the select output of this block.

Software writes all configuration fields at once: the source-select bit, where 1 means bypass, and the two divider fields. Software reads back the fields and a synchronised lock status. A request for the PLL source while lock is absent is dropped. If lock disappears while the PLL is in use, the controller falls back to bypass. A small power-mode machine gates the strobes. Idle stops only the CPU strobe. Power-down stops both strobes, is accepted only while the NMI input is low, and is left only through reset.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, bypass is selected (`sel_pll`=0), `osc_div` holds RST_OSC_DIV, `cpu_div` holds RST_CPU_DIV, the mode is run, and the strobes pulse at the reset divider ratio starting in the first cycle after reset.
- R2: A configuration write with `cfg_byp`=0 while `lock_sts`=1 sets `sel_pll` to 1 in the cycle after the write.
- R3: A configuration write with `cfg_byp`=0 while `lock_sts`=0 leaves `sel_pll` at 0.
- R4: `lock_sts` follows `pll_lock` two cycles later. While `sel_pll`=1, a cycle with `lock_sts`=0 makes `sel_pll` 0 in the next cycle.
- R5: The strobe period is field+1 cycles. The field is `osc_div` when `sel_pll`=0 and `cpu_div` when `sel_pll`=1.
- R6: A change to a divider field or to the source affects only the period that starts after the next strobe. The period already in progress keeps its old length.
- R7: In run mode, `cpu_ce` and `per_ce` pulse in the same cycles. `cpu_ce` is never high without `per_ce`.
- R8: A cycle with `idle_req`=1 in run mode enters idle. In idle, `cpu_ce` stays 0 and `per_ce` keeps pulsing.
- R9: A cycle with `irq`=1 in idle returns the block to run mode, and `cpu_ce` pulses again.
- R10: A cycle with `pdn_req`=1 in run mode enters power-down only if `nmi` is 0 in that cycle, and then both strobes stay 0. With `nmi`=1 the request has no effect. `pdn_req` takes priority over `idle_req`.
- R11: Power-down is left only by reset. `irq` has no effect there. Reset restores bypass and run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_byp | input | 1 | Written source bit: 1 bypass, 0 PLL |
| cfg_osc_div | input | OSC_W | Written oscillator-divider field |
| cfg_cpu_div | input | CPU_W | Written CPU-divider field |
| pll_lock | input | 1 | Lock indication from the PLL |
| idle_req | input | 1 | Idle request from the CPU |
| pdn_req | input | 1 | Power-down request from the CPU |
| nmi | input | 1 | Non-maskable interrupt pin level |
| irq | input | 1 | Any enabled interrupt pending |
| sel_pll | output | 1 | Clock source select, 1 = PLL |
| lock_sts | output | 1 | Synchronised lock status |
| osc_div | output | OSC_W | Programmed oscillator-divider field |
| cpu_div | output | CPU_W | Programmed CPU-divider field |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |

## Verification
The assertions assume that the request inputs are sampled as levels on each clock edge. They also assume that `pll_lock` may change in any cycle, so the synchroniser delay is the only protection against a stale lock reading. The random stimulus changes inputs only on the falling edge. It keeps `pdn_req` rare so that long stretches stay out of power-down, and it issues a reset after each random phase so that power-down is always left again. Lock is toggled with a low probability so that PLL selection, dropped requests and fallbacks all appear.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2
   } pmode_t;
endpackage

// File: rtl/cpc_lock_sync.sv
module cpc_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign lock_out = lock_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | STAGES'(lock_in);
         end
         assign lock_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cpc_cfg_regs.sv
module cpc_cfg_regs #(
   parameter int OSC_W   = 4,
   parameter int CPU_W   = 3,
   parameter int RST_OSC = 1,
   parameter int RST_CPU = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             wr_byp,
   input  logic [OSC_W-1:0] wr_osc,
   input  logic [CPU_W-1:0] wr_cpu,
   input  logic             lock_ok,
   output logic             byp_q,
   output logic [OSC_W-1:0] osc_q,
   output logic [CPU_W-1:0] cpu_q
);
   logic byp_d;

   // without lock the source is forced to bypass, which both drops
   // a PLL request and performs the fallback on lock loss
   always_comb begin
      if (!lock_ok)  byp_d = 1'b1;
      else if (we)   byp_d = wr_byp;
      else           byp_d = byp_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b1;
         osc_q <= OSC_W'(RST_OSC);
         cpu_q <= CPU_W'(RST_CPU);
      end else begin
         byp_q <= byp_d;
         if (we) begin
            osc_q <= wr_osc;
            cpu_q <= wr_cpu;
         end
      end
   end
endmodule

// File: rtl/cpc_ce_div.sv
module cpc_ce_div #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload,
   output logic         tick
);
   logic [W-1:0] cnt_q;

   assign tick = (cnt_q == '0);

   // the reload value is sampled only at a tick, so a new ratio
   // starts with the period that follows the next strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= reload;
      else           cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/cpc_pwr_fsm.sv
module cpc_pwr_fsm
   import clk_pwr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   idle_req,
   input  logic   pdn_req,
   input  logic   nmi,
   input  logic   irq,
   output pmode_t mode
);
   pmode_t mode_d;

   always_comb begin
      mode_d = mode;
      unique case (mode)
         PM_RUN: begin
            if (pdn_req && !nmi) mode_d = PM_DOWN;
            else if (idle_req)   mode_d = PM_IDLE;
         end
         PM_IDLE: if (irq) mode_d = PM_RUN;
         PM_DOWN: mode_d = PM_DOWN;
         default: mode_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= PM_RUN;
      else        mode <= mode_d;
   end
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
   import clk_pwr_pkg::*;
#(
   parameter int OSC_W       = 4,
   parameter int CPU_W       = 3,
   parameter int RST_OSC_DIV = 1,
   parameter int RST_CPU_DIV = 1,
   parameter int LOCK_SYNC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_byp,
   input  logic [OSC_W-1:0] cfg_osc_div,
   input  logic [CPU_W-1:0] cfg_cpu_div,
   input  logic             pll_lock,
   input  logic             idle_req,
   input  logic             pdn_req,
   input  logic             nmi,
   input  logic             irq,
   output logic             sel_pll,
   output logic             lock_sts,
   output logic [OSC_W-1:0] osc_div,
   output logic [CPU_W-1:0] cpu_div,
   output logic             cpu_ce,
   output logic             per_ce
);
   localparam int DIV_W = (OSC_W > CPU_W) ? OSC_W : CPU_W;

   generate
      if (OSC_W < 1 || CPU_W < 1) begin : g_bad_width
         $error("divider field widths must be at least 1");
      end
      if (RST_OSC_DIV < 0 || RST_OSC_DIV >= (1 << OSC_W)) begin : g_bad_rst_osc
         $error("RST_OSC_DIV does not fit OSC_W");
      end
      if (RST_CPU_DIV < 0 || RST_CPU_DIV >= (1 << CPU_W)) begin : g_bad_rst_cpu
         $error("RST_CPU_DIV does not fit CPU_W");
      end
      if (LOCK_SYNC < 0 || LOCK_SYNC > 4) begin : g_bad_sync
         $error("LOCK_SYNC must be 0 to 4");
      end
   endgenerate

   logic             byp_q;
   logic [DIV_W-1:0] reload;
   logic             tick;
   pmode_t           mode_q;

   cpc_lock_sync #(.STAGES(LOCK_SYNC)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (pll_lock),
      .lock_out (lock_sts)
   );

   cpc_cfg_regs #(
      .OSC_W   (OSC_W),
      .CPU_W   (CPU_W),
      .RST_OSC (RST_OSC_DIV),
      .RST_CPU (RST_CPU_DIV)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wr_byp  (cfg_byp),
      .wr_osc  (cfg_osc_div),
      .wr_cpu  (cfg_cpu_div),
      .lock_ok (lock_sts),
      .byp_q   (byp_q),
      .osc_q   (osc_div),
      .cpu_q   (cpu_div)
   );

   assign reload = byp_q ? DIV_W'(osc_div) : DIV_W'(cpu_div);

   cpc_ce_div #(.W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload),
      .tick   (tick)
   );

   cpc_pwr_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req),
      .pdn_req  (pdn_req),
      .nmi      (nmi),
      .irq      (irq),
      .mode     (mode_q)
   );

   assign sel_pll = ~byp_q;
   assign cpu_ce  = tick & (mode_q == PM_RUN);
   assign per_ce  = tick & (mode_q != PM_DOWN);
endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
module clk_pwr_ctrl_chk
   import clk_pwr_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   sel_pll,
   input logic   lock_sts,
   input logic   cpu_ce,
   input logic   per_ce,
   input logic   nmi,
   input logic   pdn_req,
   input logic   irq,
   input pmode_t mode_q
);
   p_pll_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_pll) |-> $past(lock_sts));

   p_lock_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pll && !lock_sts) |=> !sel_pll);

   p_cpu_implies_per_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ce |-> per_ce);

   p_no_cpu_out_of_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_RUN) |-> !cpu_ce);

   p_idle_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_IDLE && irq) |=> (mode_q == PM_RUN));

   p_down_needs_nmi_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_DOWN && $past(mode_q) != PM_DOWN) |-> $past(pdn_req && !nmi));

   p_down_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_DOWN) |=> (mode_q == PM_DOWN && !per_ce));
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_pll  (sel_pll),
   .lock_sts (lock_sts),
   .cpu_ce   (cpu_ce),
   .per_ce   (per_ce),
   .nmi      (nmi),
   .pdn_req  (pdn_req),
   .irq      (irq),
   .mode_q   (mode_q)
);

// File: tb/sim_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_clk_pwr_ctrl;
   localparam int OSC_W = 4;
   localparam int CPU_W = 3;
   localparam int RST_OSC = 1;
   localparam int RST_CPU = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_byp = 0, pll_lock = 0;
   logic idle_req = 0, pdn_req = 0, nmi = 0, irq = 0;
   logic [OSC_W-1:0] cfg_osc_div = '0;
   logic [CPU_W-1:0] cfg_cpu_div = '0;
   logic sel_pll, lock_sts, cpu_ce, per_ce;
   logic [OSC_W-1:0] osc_div;
   logic [CPU_W-1:0] cpu_div;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   bit       m_byp;
   int       m_osc, m_cpu, m_cnt, m_mode;
   bit [1:0] m_lk;

   always #2.5 clk = ~clk;

   clk_pwr_ctrl #(.OSC_W(OSC_W), .CPU_W(CPU_W), .RST_OSC_DIV(RST_OSC),
                  .RST_CPU_DIV(RST_CPU), .LOCK_SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_byp(cfg_byp),
      .cfg_osc_div(cfg_osc_div), .cfg_cpu_div(cfg_cpu_div), .pll_lock(pll_lock),
      .idle_req(idle_req), .pdn_req(pdn_req), .nmi(nmi), .irq(irq),
      .sel_pll(sel_pll), .lock_sts(lock_sts), .osc_div(osc_div), .cpu_div(cpu_div),
      .cpu_ce(cpu_ce), .per_ce(per_ce));

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_tick();
      return m_cnt == 0;
   endfunction

   task automatic model_reset();
      m_byp = 1; m_osc = RST_OSC; m_cpu = RST_CPU; m_cnt = 0; m_mode = 0; m_lk = 0;
   endtask

   // mode codes: 0 run, 1 idle, 2 power-down
   task automatic model_step();
      bit lk;
      int nxt;
      lk = m_lk[1];
      nxt = m_byp ? m_osc : m_cpu;
      m_cnt = m_tick() ? nxt : m_cnt - 1;
      if (!lk) m_byp = 1;
      else if (cfg_we) m_byp = cfg_byp;
      if (cfg_we) begin m_osc = int'(cfg_osc_div); m_cpu = int'(cfg_cpu_div); end
      case (m_mode)
         0: if (pdn_req && !nmi) m_mode = 2; else if (idle_req) m_mode = 1;
         1: if (irq) m_mode = 0;
         default: ;
      endcase
      m_lk = {m_lk[0], pll_lock};
   endtask

   task automatic compare();
      check("R2 sel_pll", int'(sel_pll), int'(!m_byp));
      check("R4 lock_sts", int'(lock_sts), int'(m_lk[1]));
      check("R5 osc_div", int'(osc_div), m_osc);
      check("R5 cpu_div", int'(cpu_div), m_cpu);
      check("R8 cpu_ce", int'(cpu_ce), int'(m_tick() && m_mode == 0));
      check("R7 per_ce", int'(per_ce), int'(m_tick() && m_mode != 2));
   endtask

   task automatic clear_in();
      cfg_we = 0; idle_req = 0; pdn_req = 0; irq = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      clear_in();
      rst_n = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      model_step();
      compare();
   endtask

   task automatic count_ce(int n, output int nc, output int np);
      nc = 0; np = 0;
      for (int i = 0; i < n; i++) begin
         cyc();
         clear_in();
         nc += int'(cpu_ce); np += int'(per_ce);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int nc, np;
      void'($urandom(32'h5eed));
      model_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      // R1: reset values in the first cycle after release
      rst_n = 1;
      check("R1 sel_pll", int'(sel_pll), 0);
      check("R1 osc_div", int'(osc_div), RST_OSC);
      check("R1 cpu_div", int'(cpu_div), RST_CPU);
      check("R1 per_ce first", int'(per_ce), 1);
      check("R1 cpu_ce first", int'(cpu_ce), 1);
      cyc();
      check("R1 per_ce second", int'(per_ce), 0);

      // R3: PLL request without lock is dropped
      cfg_we = 1; cfg_byp = 0; cfg_osc_div = 4'd1; cfg_cpu_div = 3'd2;
      cyc(); clear_in();
      check("R3 sel_pll stays bypass", int'(sel_pll), 0);

      // R2: with lock the request takes effect one cycle later
      pll_lock = 1;
      repeat (3) cyc();
      cfg_we = 1; cfg_byp = 0;
      cyc(); clear_in();
      check("R2 sel_pll after write", int'(sel_pll), 1);

      // R5: PLL path period = cpu_div + 1 = 3
      repeat (6) cyc();
      count_ce(12, nc, np);
      check("R5 pulses in 12 cycles", np, 4);

      // R6: change divider in a strobe cycle; old period completes
      while (!per_ce) cyc();
      cfg_we = 1; cfg_byp = 0; cfg_cpu_div = 3'd0;
      cyc(); clear_in();
      check("R6 old period 1", int'(per_ce), 0);
      cyc();
      check("R6 old period 2", int'(per_ce), 0);
      cyc();
      check("R6 old period end", int'(per_ce), 1);
      cyc();
      check("R6 new ratio", int'(per_ce), 1);

      // R4: lock loss falls back to bypass
      pll_lock = 0;
      repeat (4) cyc();
      check("R4 fallback", int'(sel_pll), 0);

      // R8: idle stops cpu strobe only (bypass, ratio 2)
      idle_req = 1;
      cyc(); clear_in();
      count_ce(6, nc, np);
      check("R8 cpu in idle", nc, 0);
      check("R8 per in idle", np, 3);

      // R9: interrupt wakes the CPU
      irq = 1;
      cyc(); clear_in();
      count_ce(4, nc, np);
      check("R9 cpu after wake", nc, 2);

      // R10: power-down with NMI high ignored, with NMI low taken
      nmi = 1; pdn_req = 1;
      cyc(); clear_in();
      count_ce(4, nc, np);
      check("R10 nmi high cpu", nc, 2);
      check("R10 nmi high per", np, 2);
      nmi = 0; pdn_req = 1; idle_req = 1;
      cyc(); clear_in();
      count_ce(8, nc, np);
      check("R10 down per", np, 0);
      check("R10 down cpu", nc, 0);

      // R11: interrupt does not leave power-down, reset does
      irq = 1;
      cyc(); clear_in();
      count_ce(6, nc, np);
      check("R11 irq in down", np, 0);
      do_reset();
      check("R11 sel after reset", int'(sel_pll), 0);
      count_ce(4, nc, np);
      check("R11 run after reset", nc, 2);

      // random phases against the model
      for (int ph = 0; ph < 6; ph++) begin
         for (int i = 0; i < 600; i++) begin
            cfg_we      = ($urandom_range(0, 9) == 0);
            cfg_byp     = $urandom_range(0, 1);
            cfg_osc_div = OSC_W'($urandom_range(0, 15));
            cfg_cpu_div = CPU_W'($urandom_range(0, 7));
            if ($urandom_range(0, 19) == 0) pll_lock = ~pll_lock;
            idle_req    = ($urandom_range(0, 19) == 0);
            pdn_req     = ($urandom_range(0, 149) == 0);
            nmi         = $urandom_range(0, 1);
            irq         = ($urandom_range(0, 9) == 0);
            cyc();
         end
         do_reset();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule